// File: doc/BRIEF.md
# SPI Serial Memory Command Front End

This block is the slave side of a four-wire serial link for a byte-addressed nonvolatile memory. It works in clock modes 0 and 3. A fast system clock oversamples the serial clock, select, data-in and pause pins. Each framed transaction brings in an 8-bit command byte, a 16-bit address where the command needs one, and data bytes, most significant bit first. For read and status commands it shifts bytes back out.

It does not hold any storage. It turns each transaction into parallel requests. Array reads and array byte writes go through a request/grant port. Write-enable set and clear, status write and array commit are one-cycle pulses, issued when select rises at the end of a well-formed sequence. The status byte and the write-busy flag come from an outside status/protection unit. The array, write timing and protection are handled outside.

The serial output comes as a data bit plus an output enable. The pad turns that into high impedance. Output is enabled only while a read or status byte is being sent, select is low and no pause is active.

Top module: `spi_mem_frontend`

## Requirements
- R1: The command byte is decoded as 0x06 set-write-enable, 0x04 clear-write-enable, 0x05 status read, 0x01 status write, 0x03 array read, 0x02 array write. Any other value is unrecognised.
- R2: Input bits are taken on rising serial-clock edges, most significant bit first. Output bits change on falling edges, most significant bit first. The output enable is low during command and address bits.
- R3: Array read and write take a 16-bit address after the command byte. Only the low AW bits are used and the higher bits are ignored.
- R4: An array read returns the byte at the address, then the next addresses in turn, one per further byte. The address wraps from the top of the AW-bit space to zero, so reading can go on without end.
- R5: A status read returns the status byte input, sampled again for each further byte.
- R6: Set-write-enable and clear-write-enable each pulse their output once when select rises after exactly 8 bits. With any other bit count there is no pulse.
- R7: An array write issues one write request per complete data byte. The first request goes to the given address. Each later one increments only the low PAGE_BITS address bits, which wrap within the page. One commit pulse follows when select rises on a byte boundary after at least one byte.
- R8: A status write pulses `sr_wr` once at the rising edge of select, when at least one whole byte has been sent on a byte boundary. `sr_wdata` then holds the last complete byte.
- R9: Select high ends any sequence and disables the output. A partial data byte is not requested, and a sequence cut mid-byte gives no pulse.
- R10: Pause low while the serial clock is low freezes the sequence. Output is disabled and clock and data edges are ignored. Pause high while the clock is low resumes at the same bit.
- R11: After an unrecognised command byte there is no request, pulse or output until select falls again.
- R12: While `write_busy` is high, every command except status read is ignored. Status read still works.
- R13: A memory request holds its address and direction steady until it is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock |
| spi_cs_n | input | 1 | Active-low select |
| spi_si | input | 1 | Serial data in |
| spi_hold_n | input | 1 | Active-low pause |
| spi_so | output | 1 | Serial data out |
| spi_so_oe | output | 1 | Output enable; the pad is high impedance when low |
| mem_req | output | 1 | Array access request, held until granted |
| mem_we | output | 1 | Request direction: 1 write, 0 read |
| mem_addr | output | AW | Array byte address |
| mem_wdata | output | 8 | Byte to write |
| mem_gnt | input | 1 | One-cycle grant; read data valid with it |
| mem_rdata | input | 8 | Read data |
| write_busy | input | 1 | Internal write cycle in progress |
| stat_byte | input | 8 | Status byte to send on a status read |
| wel_set | output | 1 | Set write-enable pulse |
| wel_clr | output | 1 | Clear write-enable pulse |
| sr_wr | output | 1 | Status write pulse |
| sr_wdata | output | 8 | Status byte to write, valid with `sr_wr` |
| wr_commit | output | 1 | Start internal array write pulse |

## Verification
The embedded properties watch on every cycle several things: that a pending request keeps its address until granted, that write requests stay inside one page, that command pulses never overlap, that a busy flag sends any command other than status read to the dead state, and that the output is frozen and disabled while paused. Whether the right bytes appear in the right order can only be shown by the bench's scenarios. The same holds for address wrap and ignored upper address bits, pulses that need an exact bit count, a write cut off mid-byte, and a pause in the middle of a data byte. The bench runs these in both clock modes against an arithmetic memory pattern.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;

   localparam logic [7:0] OP_WEN_SET = 8'h06;
   localparam logic [7:0] OP_WEN_CLR = 8'h04;
   localparam logic [7:0] OP_STAT_RD = 8'h05;
   localparam logic [7:0] OP_STAT_WR = 8'h01;
   localparam logic [7:0] OP_ARR_RD  = 8'h03;
   localparam logic [7:0] OP_ARR_WR  = 8'h02;

   typedef enum logic [1:0] {
      PH_OPC,
      PH_ADDR,
      PH_DATA,
      PH_DEAD
   } phase_t;

   typedef enum logic [2:0] {
      C_NONE,
      C_WREN,
      C_WRDI,
      C_RDSR,
      C_WRSR,
      C_READ,
      C_WRITE
   } cmd_t;

   function automatic cmd_t op_decode(input logic [7:0] op);
      case (op)
         OP_WEN_SET: return C_WREN;
         OP_WEN_CLR: return C_WRDI;
         OP_STAT_RD: return C_RDSR;
         OP_STAT_WR: return C_WRSR;
         OP_ARR_RD:  return C_READ;
         OP_ARR_WR:  return C_WRITE;
         default:    return C_NONE;
      endcase
   endfunction

endpackage

// File: rtl/spi_mem_sync.sv
module spi_mem_sync #(
   parameter int             W       = 4,
   parameter int             STAGES  = 2,
   parameter logic [W-1:0]   RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_async,
   output logic [W-1:0] d_sync
);

   initial begin
      assert (STAGES >= 2) else $error("spi_mem_sync: STAGES must be at least 2");
   end

   for (genvar g = 0; g < STAGES; g++) begin : g_st
      logic [W-1:0] q;
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= RST_VAL;
            else        q <= d_async;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= RST_VAL;
            else        q <= g_st[g-1].q;
         end
      end
   end

   assign d_sync = g_st[STAGES-1].q;

endmodule

// File: rtl/spi_mem_seq.sv
module spi_mem_seq
   import spi_mem_pkg::*;
#(
   parameter int AW        = 15,
   parameter int PAGE_BITS = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sck_lvl,
   input  logic          cs_lvl,
   input  logic          si_lvl,
   input  logic          hold_lvl,
   input  logic          write_busy,
   input  logic [7:0]    stat_byte,
   input  logic          mem_gnt,
   input  logic [7:0]    mem_rdata,
   output logic          mem_req,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [7:0]    mem_wdata,
   output logic          wel_set,
   output logic          wel_clr,
   output logic          sr_wr,
   output logic [7:0]    sr_wdata,
   output logic          wr_commit,
   output logic          so_load,
   output logic [7:0]    so_byte,
   output logic          so_shift,
   output logic          sel,
   output logic          out_active,
   output logic          held
);

   localparam logic [AW-1:0] PAGE_MASK = AW'((64'd1 << PAGE_BITS) - 64'd1);

   phase_t        phase;
   cmd_t          cmd;
   logic [4:0]    bitcnt;
   logic [15:0]   shreg;
   logic          got_byte;
   logic [7:0]    rdbuf;
   logic          sck_d, cs_d;

   logic          sck_rise, sck_fall, cs_rise;
   logic          step, fstep;
   logic [15:0]   sh_next;
   cmd_t          opc_cmd;
   logic [AW-1:0] addr_inc, page_inc;
   logic          rd_type;

   // edge detection on the synchronised levels
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_d <= 1'b0;
         cs_d  <= 1'b1;
      end else begin
         sck_d <= sck_lvl;
         cs_d  <= cs_lvl;
      end
   end

   assign sck_rise   = sck_lvl & ~sck_d;
   assign sck_fall   = ~sck_lvl & sck_d;
   assign cs_rise    = cs_lvl & ~cs_d;
   assign sel        = ~cs_lvl;
   assign step       = sck_rise & sel & ~held;
   assign fstep      = sck_fall & sel & ~held;
   assign sh_next    = {shreg[14:0], si_lvl};
   assign opc_cmd    = op_decode(sh_next[7:0]);
   assign addr_inc   = AW'(mem_addr + 1'b1);
   assign page_inc   = (mem_addr & ~PAGE_MASK) | (addr_inc & PAGE_MASK);
   assign rd_type    = (cmd == C_READ) || (cmd == C_RDSR);
   assign out_active = (phase == PH_DATA) && rd_type;

   // pause: only changes state while the serial clock is low
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        held <= 1'b0;
      else if (!sel)     held <= 1'b0;
      else if (!sck_lvl) held <= ~hold_lvl;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase     <= PH_OPC;
         cmd       <= C_NONE;
         bitcnt    <= '0;
         shreg     <= '0;
         got_byte  <= 1'b0;
         rdbuf     <= '0;
         mem_req   <= 1'b0;
         mem_we    <= 1'b0;
         mem_addr  <= '0;
         mem_wdata <= '0;
         sr_wdata  <= '0;
         so_byte   <= '0;
         wel_set   <= 1'b0;
         wel_clr   <= 1'b0;
         sr_wr     <= 1'b0;
         wr_commit <= 1'b0;
         so_load   <= 1'b0;
         so_shift  <= 1'b0;
      end else begin
         wel_set   <= 1'b0;
         wel_clr   <= 1'b0;
         sr_wr     <= 1'b0;
         wr_commit <= 1'b0;
         so_load   <= 1'b0;
         so_shift  <= 1'b0;

         if (mem_gnt) begin
            mem_req <= 1'b0;
            if (!mem_we) rdbuf    <= mem_rdata;
            else         mem_addr <= page_inc;
         end

         if (!sel) begin
            phase    <= PH_OPC;
            cmd      <= C_NONE;
            bitcnt   <= '0;
            got_byte <= 1'b0;
            if (cs_rise && phase == PH_DATA && bitcnt == 5'd0) begin
               case (cmd)
                  C_WREN:  wel_set   <= ~got_byte;
                  C_WRDI:  wel_clr   <= ~got_byte;
                  C_WRSR:  sr_wr     <= got_byte;
                  C_WRITE: wr_commit <= got_byte;
                  default: ;
               endcase
            end
         end else begin
            if (step) begin
               shreg <= sh_next;
               case (phase)
                  PH_OPC: begin
                     if (bitcnt == 5'd7) begin
                        bitcnt <= '0;
                        if (opc_cmd == C_NONE || (write_busy && opc_cmd != C_RDSR)) begin
                           phase <= PH_DEAD;
                        end else begin
                           cmd   <= opc_cmd;
                           phase <= (opc_cmd == C_READ || opc_cmd == C_WRITE) ? PH_ADDR : PH_DATA;
                        end
                     end else begin
                        bitcnt <= bitcnt + 5'd1;
                     end
                  end
                  PH_ADDR: begin
                     if (bitcnt == 5'd15) begin
                        bitcnt   <= '0;
                        phase    <= PH_DATA;
                        mem_addr <= AW'(sh_next);
                        if (cmd == C_READ) begin
                           mem_req <= 1'b1;
                           mem_we  <= 1'b0;
                        end
                     end else begin
                        bitcnt <= bitcnt + 5'd1;
                     end
                  end
                  PH_DATA: begin
                     if (bitcnt == 5'd7) begin
                        bitcnt   <= '0;
                        got_byte <= 1'b1;
                        if (cmd == C_WRITE) begin
                           mem_req   <= 1'b1;
                           mem_we    <= 1'b1;
                           mem_wdata <= sh_next[7:0];
                        end
                        if (cmd == C_WRSR) sr_wdata <= sh_next[7:0];
                     end else begin
                        bitcnt <= bitcnt + 5'd1;
                     end
                  end
                  default: ;
               endcase
            end

            if (fstep && out_active) begin
               if (bitcnt == 5'd0) begin
                  so_load <= 1'b1;
                  so_byte <= (cmd == C_READ) ? rdbuf : stat_byte;
                  if (cmd == C_READ) begin
                     mem_addr <= addr_inc;
                     mem_req  <= 1'b1;
                     mem_we   <= 1'b0;
                  end
               end else begin
                  so_shift <= 1'b1;
               end
            end
         end
      end
   end

   // R13
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

   // R7
   page_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we && mem_gnt) |=> ((mem_addr & ~PAGE_MASK) == ($past(mem_addr) & ~PAGE_MASK)));

   // R12
   busy_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step && phase == PH_OPC && bitcnt == 5'd7 && write_busy) |=> (phase == PH_DEAD || cmd == C_RDSR));

   // R11
   dead_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_DEAD && $past(phase == PH_DEAD)) |-> (!so_load && !so_shift && !wel_set && !wr_commit));

   // R6
   pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({wel_set, wel_clr, sr_wr, wr_commit}));

endmodule

// File: rtl/spi_mem_so.sv
module spi_mem_so (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sel,
   input  logic       held,
   input  logic       active,
   input  logic       load,
   input  logic [7:0] load_byte,
   input  logic       shift,
   output logic       so,
   output logic       so_oe
);

   logic [7:0] sh;
   logic       live;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh   <= '0;
         live <= 1'b0;
      end else if (!sel) begin
         live <= 1'b0;
      end else if (load) begin
         sh   <= load_byte;
         live <= 1'b1;
      end else if (shift) begin
         sh   <= {sh[6:0], 1'b0};
      end
   end

   assign so    = sh[7];
   assign so_oe = sel & ~held & active & live;

endmodule

// File: rtl/spi_mem_frontend.sv
module spi_mem_frontend #(
   parameter int AW          = 15,
   parameter int PAGE_BITS   = 6,
   parameter int SYNC_STAGES = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          spi_sck,
   input  logic          spi_cs_n,
   input  logic          spi_si,
   input  logic          spi_hold_n,
   output logic          spi_so,
   output logic          spi_so_oe,
   output logic          mem_req,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [7:0]    mem_wdata,
   input  logic          mem_gnt,
   input  logic [7:0]    mem_rdata,
   input  logic          write_busy,
   input  logic [7:0]    stat_byte,
   output logic          wel_set,
   output logic          wel_clr,
   output logic          sr_wr,
   output logic [7:0]    sr_wdata,
   output logic          wr_commit
);

   initial begin
      assert (AW > PAGE_BITS && AW <= 16) else $error("spi_mem_frontend: need PAGE_BITS < AW <= 16");
      assert (PAGE_BITS >= 1) else $error("spi_mem_frontend: PAGE_BITS must be at least 1");
   end

   logic [3:0] lvl;
   logic       sel, out_active, held;
   logic       so_load, so_shift;
   logic [7:0] so_byte;

   spi_mem_sync #(
      .W       (4),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (4'b1110)
   ) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async ({spi_hold_n, spi_si, spi_cs_n, spi_sck}),
      .d_sync  (lvl)
   );

   spi_mem_seq #(
      .AW        (AW),
      .PAGE_BITS (PAGE_BITS)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .sck_lvl    (lvl[0]),
      .cs_lvl     (lvl[1]),
      .si_lvl     (lvl[2]),
      .hold_lvl   (lvl[3]),
      .write_busy (write_busy),
      .stat_byte  (stat_byte),
      .mem_gnt    (mem_gnt),
      .mem_rdata  (mem_rdata),
      .mem_req    (mem_req),
      .mem_we     (mem_we),
      .mem_addr   (mem_addr),
      .mem_wdata  (mem_wdata),
      .wel_set    (wel_set),
      .wel_clr    (wel_clr),
      .sr_wr      (sr_wr),
      .sr_wdata   (sr_wdata),
      .wr_commit  (wr_commit),
      .so_load    (so_load),
      .so_byte    (so_byte),
      .so_shift   (so_shift),
      .sel        (sel),
      .out_active (out_active),
      .held       (held)
   );

   spi_mem_so u_so (
      .clk       (clk),
      .rst_n     (rst_n),
      .sel       (sel),
      .held      (held),
      .active    (out_active),
      .load      (so_load),
      .load_byte (so_byte),
      .shift     (so_shift),
      .so        (spi_so),
      .so_oe     (spi_so_oe)
   );

   // R10
   hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (held && $past(held)) |-> ($stable(spi_so) && !spi_so_oe));

endmodule

// File: tb/spi_mem_frontend_test.sv
`timescale 1ns/1ps
module spi_mem_frontend_test;

   localparam int AW = 8;
   localparam int PB = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          spi_sck = 1'b0;
   logic          spi_cs_n = 1'b1;
   logic          spi_si = 1'b1;
   logic          spi_hold_n = 1'b1;
   logic          write_busy = 1'b0;
   logic [7:0]    stat_byte = 8'h8C;
   logic          mem_gnt = 1'b0;
   logic [7:0]    mem_rdata = 8'h00;
   logic          spi_so, spi_so_oe, mem_req, mem_we;
   logic [AW-1:0] mem_addr;
   logic [7:0]    mem_wdata, sr_wdata;
   logic          wel_set, wel_clr, sr_wr, wr_commit;

   always #2.5 clk = ~clk;

   spi_mem_frontend #(.AW(AW), .PAGE_BITS(PB), .SYNC_STAGES(2)) uut (
      .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
      .spi_si(spi_si), .spi_hold_n(spi_hold_n), .spi_so(spi_so), .spi_so_oe(spi_so_oe),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_gnt(mem_gnt), .mem_rdata(mem_rdata), .write_busy(write_busy),
      .stat_byte(stat_byte), .wel_set(wel_set), .wel_clr(wel_clr), .sr_wr(sr_wr),
      .sr_wdata(sr_wdata), .wr_commit(wr_commit)
   );

   function automatic logic [7:0] pat(input int a);
      return 8'((a * 37 + 11) & 255);
   endfunction

   int n_chk = 0, n_fail = 0;
   int n_oe = 0, n_rd = 0, n_wr = 0, n_wset = 0, n_wclr = 0, n_srwr = 0, n_commit = 0;
   logic [AW-1:0] wlog_a [0:15];
   logic [7:0]    wlog_d [0:15];
   logic          cpol = 1'b0;

   // memory model: one-cycle grant, data computed from the address
   always @(posedge clk) begin
      mem_gnt   <= mem_req && !mem_gnt;
      mem_rdata <= pat(int'(mem_addr));
      if (spi_so_oe) n_oe++;
      if (mem_req && mem_gnt && !mem_we) n_rd++;
      if (mem_req && mem_gnt && mem_we) begin
         if (n_wr < 16) begin
            wlog_a[n_wr] <= mem_addr;
            wlog_d[n_wr] <= mem_wdata;
         end
         n_wr++;
      end
      if (wel_set)   n_wset++;
      if (wel_clr)   n_wclr++;
      if (sr_wr)     n_srwr++;
      if (wr_commit) n_commit++;
   end

   task automatic check(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic bits(input logic [7:0] tx, input int hi, input int lo,
                       inout logic [7:0] rx, inout int oe_hits);
      for (int i = hi; i >= lo; i--) begin
         spi_sck = 1'b0;
         spi_si  = tx[i];
         #40;
         rx[i] = spi_so;
         if (spi_so_oe) oe_hits++;
         spi_sck = 1'b1;
         #40;
      end
   endtask

   task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx, output int oe_hits);
      logic [7:0] r = 8'h00;
      int h = 0;
      bits(tx, 7, 0, r, h);
      rx = r;
      oe_hits = h;
   endtask

   task automatic seq_begin();
      spi_sck = cpol;
      #40;
      spi_cs_n = 1'b0;
      #40;
   endtask

   task automatic seq_end();
      if (!cpol) begin
         spi_sck = 1'b0;
         #40;
      end
      spi_cs_n = 1'b1;
      #40;
      spi_sck = cpol;
      #160;
   endtask

   task automatic do_read(input logic [15:0] a, input int nb, input string tag);
      logic [7:0] rx;
      int h, hsum;
      hsum = 0;
      seq_begin();
      xbyte(8'h03, rx, h); hsum += h;
      xbyte(a[15:8], rx, h); hsum += h;
      xbyte(a[7:0], rx, h); hsum += h;
      check({tag, " R2 oe low in command/address"}, hsum, 0);
      for (int k = 0; k < nb; k++) begin
         xbyte(8'hFF, rx, h);
         check({tag, " data"}, rx, pat((int'(a) + k) & 255));
         check({tag, " R2 oe during data bits"}, h, 8);
      end
      seq_end();
      check({tag, " R9 oe low after select high"}, spi_so_oe, 0);
   endtask

   task automatic send(input logic [7:0] b);
      logic [7:0] rx;
      int h;
      xbyte(b, rx, h);
   endtask

   task automatic finish_up();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      #500000;
      n_fail++;
      $display("FAIL watchdog expired");
      finish_up();
   end

   initial begin
      logic [7:0] rx;
      int h, b_oe, b_rd, b_wr, b_set, b_clr, b_sr, b_cm, hsum;
      #100;
      rst_n = 1'b1;
      #100;
      check("reset oe", spi_so_oe, 0);
      check("reset req", mem_req, 0);

      // R4 array read, mode 0
      cpol = 1'b0;
      do_read(16'h0010, 4, "R4 mode0 read");
      // R4 wrap at top of array, mode 3
      cpol = 1'b1;
      do_read(16'h00FE, 3, "R4 mode3 wrap");
      // R3 upper address bits ignored
      do_read(16'h7F05, 2, "R3 upper bits");
      cpol = 1'b0;

      // R5 status read, repeated
      seq_begin();
      send(8'h05);
      xbyte(8'h00, rx, h); check("R5 status byte", rx, 8'h8C);
      stat_byte = 8'h3A;
      xbyte(8'h00, rx, h); check("R5 status resampled", rx, 8'h3A);
      seq_end();
      stat_byte = 8'h8C;

      // R6 / R1 set and clear write enable
      b_set = n_wset; b_clr = n_wclr;
      seq_begin(); send(8'h06); seq_end();
      check("R6 set pulse", n_wset - b_set, 1);
      seq_begin(); send(8'h04); seq_end();
      check("R6 clear pulse", n_wclr - b_clr, 1);
      b_set = n_wset;
      seq_begin(); send(8'h06); send(8'h00); seq_end();
      check("R6 no pulse with 16 bits", n_wset - b_set, 0);

      // R7 array write with page wrap
      b_wr = n_wr; b_cm = n_commit; b_oe = n_oe;
      seq_begin();
      send(8'h02); send(8'h00); send(8'h2E);
      send(8'hA1); send(8'hB2); send(8'hC3);
      seq_end();
      check("R7 write count", n_wr - b_wr, 3);
      check("R7 addr0", wlog_a[b_wr], 8'h2E);
      check("R7 addr1", wlog_a[b_wr+1], 8'h2F);
      check("R7 addr2 page wrap", wlog_a[b_wr+2], 8'h20);
      check("R7 data0", wlog_d[b_wr], 8'hA1);
      check("R7 data2", wlog_d[b_wr+2], 8'hC3);
      check("R7 commit", n_commit - b_cm, 1);
      check("R2 no output on write", n_oe - b_oe, 0);

      // R9 write cut mid-byte
      b_wr = n_wr; b_cm = n_commit;
      seq_begin();
      send(8'h02); send(8'h00); send(8'h40); send(8'h55);
      rx = 8'h00; h = 0;
      bits(8'hF0, 7, 4, rx, h);
      seq_end();
      check("R9 only whole byte requested", n_wr - b_wr, 1);
      check("R9 no commit mid-byte", n_commit - b_cm, 0);

      // R8 status write
      b_sr = n_srwr;
      seq_begin(); send(8'h01); send(8'h9C); seq_end();
      check("R8 status write pulse", n_srwr - b_sr, 1);
      check("R8 status write data", sr_wdata, 8'h9C);

      // R12 busy: only status read honoured
      write_busy = 1'b1;
      b_oe = n_oe; b_rd = n_rd; b_set = n_wset; b_wr = n_wr; b_cm = n_commit;
      seq_begin(); send(8'h03); send(8'h00); send(8'h10); send(8'h00); send(8'h00); seq_end();
      seq_begin(); send(8'h06); seq_end();
      seq_begin(); send(8'h02); send(8'h00); send(8'h10); send(8'h77); seq_end();
      check("R12 busy read no output", n_oe - b_oe, 0);
      check("R12 busy read no request", n_rd - b_rd, 0);
      check("R12 busy set-enable ignored", n_wset - b_set, 0);
      check("R12 busy write ignored", (n_wr - b_wr) + (n_commit - b_cm), 0);
      seq_begin(); send(8'h05);
      xbyte(8'h00, rx, h); check("R12 status read while busy", rx, 8'h8C);
      seq_end();
      write_busy = 1'b0;

      // R11 unrecognised command
      b_oe = n_oe; b_rd = n_rd; b_wr = n_wr;
      seq_begin(); send(8'hAB); send(8'h03); send(8'h00); send(8'h10); send(8'hFF); seq_end();
      check("R11 no output after bad command", n_oe - b_oe, 0);
      check("R11 no request after bad command", (n_rd - b_rd) + (n_wr - b_wr), 0);
      do_read(16'h0033, 1, "R11 recovery on new select");

      // R10 pause in the middle of a data byte
      cpol = 1'b1;
      seq_begin();
      send(8'h03); send(8'h00); send(8'h40);
      rx = 8'h00; hsum = 0;
      bits(8'hFF, 7, 4, rx, hsum);
      spi_sck = 1'b0;
      #80;
      spi_hold_n = 1'b0;
      #80;
      check("R10 oe low while paused", spi_so_oe, 0);
      for (int j = 0; j < 3; j++) begin
         spi_si = j[0]; spi_sck = 1'b1; #40; spi_sck = 1'b0; #40;
      end
      check("R10 oe still low after clock edges", spi_so_oe, 0);
      spi_hold_n = 1'b1;
      #80;
      bits(8'hFF, 3, 0, rx, hsum);
      check("R10 byte resumed intact", rx, pat(8'h40));
      xbyte(8'hFF, rx, h);
      check("R10 next byte after pause", rx, pat(8'h41));
      seq_end();
      cpol = 1'b0;

      finish_up();
   end

endmodule